// File: doc/BRIEF.md
# CPU Clock Source and Divider Control

This block picks the clock that paces the CPU and the rate at which it runs. Three clock sources come in: a main clock, a low-speed on-chip oscillator and a high-speed on-chip oscillator. Each one is modelled as a one-cycle tick on a single system clock. A handful of configuration bits select the source and the division ratio. The block produces one clock-enable strobe, `cpuClkEn`, at the divided rate of the active source.

It also reports which source is active and which divisor is in effect. The request for a new source is checked first. The switch then waits until that source signals that it is stable, and the old source keeps running in the meantime. A divisor change is applied only at the end of the current divided period. A main-clock request is refused and flagged when the main oscillator is stopped or its input pin is disabled.

After reset the block runs from the low-speed oscillator at divide-by-8. Software can therefore raise the speed later from a known, slow state.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: With `div8Ovr` at 0, the two-bit `divField` sets the requested divisor as follows: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R2: With `div8Ovr` at 1, the requested divisor is 8 whatever `divField` holds.
- R3: The requested source is decoded as follows:
  - `srcSel` = 0 requests main.
  - `srcSel` = 1 with `highOscSel` = 1 and `highOscEn` = 1 requests high-speed.
  - `srcSel` = 1 with `highOscSel` = 0 and `lowOscOff` = 0 requests low-speed.
  - Any other combination with `srcSel` = 1 is ignored, and the active source stays unchanged.
- R4: A request for a source other than the active one is held pending, and the old source stays active. The request is taken at the first clock edge where the requested source's stable input (`mainStable`, `lowStable` or `highStable`) is 1. `activeSrc` shows the new source from the next cycle.
- R5: A main request with `mainStop` = 1 or `pinEn` = 0 is ignored, and the active source stays unchanged. `cfgErr` is 1 in the cycle after any cycle holding such a request, and 0 in the cycle after any other cycle.
- R6: A new requested divisor takes effect only at a clock edge where `cpuClkEn` is 1. At a source switch the divided period restarts from zero and the requested divisor is loaded.
- R7: While `rst` is 1, and in the cycle after it, the following hold: `activeSrc` = 1 (low-speed), `activeDiv` = 8, `cfgErr` = 0 and `cpuClkEn` = 0.
- R8: Let N be the divisor in effect. `cpuClkEn` is 1 only in a cycle where the active source's tick is 1, and only on every N-th such tick counted from the last period restart. Ticks of the other sources have no effect.
- R9: The `activeSrc` code is 0 for main, 1 for low-speed and 2 for high-speed. `activeDiv` carries the divisor value in binary: 1, 2, 4, 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mainTick | input | 1 | Main clock tick (enable) |
| lowTick | input | 1 | Low-speed oscillator tick |
| highTick | input | 1 | High-speed oscillator tick |
| mainStable | input | 1 | Main oscillator stable |
| lowStable | input | 1 | Low-speed oscillator stable |
| highStable | input | 1 | High-speed oscillator stable |
| srcSel | input | 1 | 0 = main, 1 = on-chip oscillator |
| mainStop | input | 1 | 1 = main oscillator stopped |
| pinEn | input | 1 | 1 = main clock input pins enabled |
| lowOscOff | input | 1 | 0 = low-speed oscillator on |
| highOscEn | input | 1 | 1 = high-speed oscillator on |
| highOscSel | input | 1 | On-chip variant select, 1 = high-speed |
| divField | input | 2 | Division field |
| div8Ovr | input | 1 | Divide-by-8 override |
| cpuClkEn | output | 1 | CPU clock-enable strobe |
| activeSrc | output | 2 | Active source code |
| activeDiv | output | 5 | Divisor in effect |
| cfgErr | output | 1 | Illegal main request seen last cycle |

## Verification
A wrong active-source register shows on `activeSrc` in the very next cycle. It also shifts the `cpuClkEn` pulses onto the wrong tick stream within one divided period. A miscounting divider or a divisor loaded off the period boundary shows up as a misplaced or missing strobe within at most sixteen ticks of the active source. A missed stability hold-off shows as an early `activeSrc` change. A cycle-accurate reference model in the bench compares all four outputs on every cycle, under random ticks, random stability and random configuration, plus directed cases for reset, the divide-by-8 override, pending switches and refused main requests.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  parameter int DIV_LOG_MAX = 4;
  localparam int CNT_W = DIV_LOG_MAX;
  localparam int EXP_W = $clog2(DIV_LOG_MAX + 1);
  localparam int DIV_W = DIV_LOG_MAX + 1;
  localparam logic [EXP_W-1:0] RESET_EXP = EXP_W'(3);

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2
  } src_e;

  typedef struct packed {
    logic             doSwitch;
    src_e             curSrc;
    logic [EXP_W-1:0] reqExp;
  } ctrl_t;
endpackage

// File: rtl/cclk_ctrl.sv
module cclk_ctrl
  import cclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       srcSel,
  input  logic       mainStop,
  input  logic       pinEn,
  input  logic       lowOscOff,
  input  logic       highOscEn,
  input  logic       highOscSel,
  input  logic [1:0] divField,
  input  logic       div8Ovr,
  input  logic       mainStable,
  input  logic       lowStable,
  input  logic       highStable,
  output ctrl_t      strobes,
  output logic       cfgErr
);
  src_e activeSrc;
  src_e reqSrc;
  logic reqValid;
  logic reqStable;
  logic [EXP_W-1:0] reqExp;
  logic badMain;

  always_comb begin
    reqSrc   = activeSrc;
    reqValid = 1'b0;
    if (!srcSel) begin
      reqSrc   = SRC_MAIN;
      reqValid = !mainStop && pinEn;
    end else if (highOscSel && highOscEn) begin
      reqSrc   = SRC_HIGH;
      reqValid = 1'b1;
    end else if (!highOscSel && !lowOscOff) begin
      reqSrc   = SRC_LOW;
      reqValid = 1'b1;
    end
  end

  always_comb begin
    case (reqSrc)
      SRC_MAIN: reqStable = mainStable;
      SRC_LOW:  reqStable = lowStable;
      SRC_HIGH: reqStable = highStable;
      default:  reqStable = 1'b0;
    endcase
  end

  always_comb begin
    if (div8Ovr) reqExp = EXP_W'(3);
    else begin
      case (divField)
        2'b00:   reqExp = EXP_W'(0);
        2'b01:   reqExp = EXP_W'(1);
        2'b10:   reqExp = EXP_W'(2);
        default: reqExp = EXP_W'(DIV_LOG_MAX);
      endcase
    end
  end

  assign badMain = !srcSel && (mainStop || !pinEn);

  always_ff @(posedge clk) begin
    if (rst) begin
      activeSrc <= SRC_LOW;
      cfgErr    <= 1'b0;
    end else begin
      if (strobes.doSwitch) activeSrc <= reqSrc;
      cfgErr <= badMain;
    end
  end

  assign strobes.doSwitch = reqValid && (reqSrc != activeSrc) && reqStable;
  assign strobes.curSrc   = activeSrc;
  assign strobes.reqExp   = reqExp;
endmodule

// File: rtl/cclk_dp.sv
module cclk_dp
  import cclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            strobes,
  input  logic             mainTick,
  input  logic             lowTick,
  input  logic             highTick,
  output logic             cpuClkEn,
  output logic [DIV_W-1:0] activeDiv
);
  logic [CNT_W-1:0] cnt;
  logic [EXP_W-1:0] curExp;
  logic [CNT_W:0]   fullDiv;
  logic [CNT_W-1:0] periodMax;
  logic             srcTick;
  logic             periodEnd;

  always_comb begin
    case (strobes.curSrc)
      SRC_MAIN: srcTick = mainTick;
      SRC_LOW:  srcTick = lowTick;
      SRC_HIGH: srcTick = highTick;
      default:  srcTick = 1'b0;
    endcase
  end

  assign fullDiv   = (CNT_W+1)'(1) << curExp;
  assign periodMax = CNT_W'(fullDiv - (CNT_W+1)'(1));
  assign periodEnd = srcTick && (cnt == periodMax);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      curExp <= RESET_EXP;
    end else if (strobes.doSwitch) begin
      cnt    <= '0;
      curExp <= strobes.reqExp;
    end else if (periodEnd) begin
      cnt    <= '0;
      curExp <= strobes.reqExp;
    end else if (srcTick) begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  assign cpuClkEn  = periodEnd && !rst;
  assign activeDiv = DIV_W'(fullDiv);
endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import cclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mainTick,
  input  logic             lowTick,
  input  logic             highTick,
  input  logic             mainStable,
  input  logic             lowStable,
  input  logic             highStable,
  input  logic             srcSel,
  input  logic             mainStop,
  input  logic             pinEn,
  input  logic             lowOscOff,
  input  logic             highOscEn,
  input  logic             highOscSel,
  input  logic [1:0]       divField,
  input  logic             div8Ovr,
  output logic             cpuClkEn,
  output logic [1:0]       activeSrc,
  output logic [DIV_W-1:0] activeDiv,
  output logic             cfgErr
);
  ctrl_t strobes;

  cclk_ctrl ctrl_i (
    .clk(clk), .rst(rst), .srcSel(srcSel), .mainStop(mainStop), .pinEn(pinEn),
    .lowOscOff(lowOscOff), .highOscEn(highOscEn), .highOscSel(highOscSel),
    .divField(divField), .div8Ovr(div8Ovr), .mainStable(mainStable),
    .lowStable(lowStable), .highStable(highStable), .strobes(strobes),
    .cfgErr(cfgErr)
  );

  cclk_dp dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .mainTick(mainTick),
    .lowTick(lowTick), .highTick(highTick), .cpuClkEn(cpuClkEn),
    .activeDiv(activeDiv)
  );

  assign activeSrc = strobes.curSrc;
endmodule

// File: rtl/cclk_chk.sv
module cclk_chk
  import cclk_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mainTick,
  input logic             lowTick,
  input logic             highTick,
  input logic             mainStable,
  input logic             lowStable,
  input logic             highStable,
  input logic             srcSel,
  input logic             mainStop,
  input logic             pinEn,
  input logic             cpuClkEn,
  input logic [1:0]       activeSrc,
  input logic [DIV_W-1:0] activeDiv,
  input logic             cfgErr
);
  AST_EN_ON_SRC_TICK: assert property (@(posedge clk) disable iff (rst)
    cpuClkEn |-> ((activeSrc == 2'd0) ? mainTick : (activeSrc == 2'd1) ? lowTick : highTick)); // R8

  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(activeDiv) == 1); // R9

  AST_SRC_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    activeSrc != 2'd3); // R9

  AST_SWITCH_NEEDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (activeSrc != $past(activeSrc)) |->
      ((activeSrc == 2'd0) ? $past(mainStable) : (activeSrc == 2'd1) ? $past(lowStable) : $past(highStable))); // R4

  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (activeDiv != $past(activeDiv)) |-> ($past(cpuClkEn) || (activeSrc != $past(activeSrc)))); // R6

  AST_BAD_MAIN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!srcSel && (mainStop || !pinEn)) |=> cfgErr); // R5

  AST_NO_BAD_MAIN_SWITCH: assert property (@(posedge clk) disable iff (rst)
    ((activeSrc == 2'd0) && ($past(activeSrc) != 2'd0)) |-> $past(!srcSel && !mainStop && pinEn)); // R5
endmodule

bind cpu_clk_ctrl cclk_chk chk_i (
  .clk(clk), .rst(rst), .mainTick(mainTick), .lowTick(lowTick), .highTick(highTick),
  .mainStable(mainStable), .lowStable(lowStable), .highStable(highStable),
  .srcSel(srcSel), .mainStop(mainStop), .pinEn(pinEn), .cpuClkEn(cpuClkEn),
  .activeSrc(activeSrc), .activeDiv(activeDiv), .cfgErr(cfgErr)
);

// File: tb/cpu_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mainTick = 0, lowTick = 0, highTick = 0;
  logic mainStable = 1, lowStable = 1, highStable = 1;
  logic srcSel = 1, mainStop = 0, pinEn = 1, lowOscOff = 0, highOscEn = 0, highOscSel = 0;
  logic [1:0] divField = 2'b00;
  logic div8Ovr = 1;
  logic cpuClkEn;
  logic [1:0] activeSrc;
  logic [4:0] activeDiv;
  logic cfgErr;

  int checks = 0;
  int fails = 0;
  bit checkOn = 0;
  bit randStable = 0;

  int mSrc, mDiv, mCnt;
  bit mErr;

  always #2.5 clk = ~clk;

  cpu_clk_ctrl dut_i (
    .clk(clk), .rst(rst), .mainTick(mainTick), .lowTick(lowTick), .highTick(highTick),
    .mainStable(mainStable), .lowStable(lowStable), .highStable(highStable),
    .srcSel(srcSel), .mainStop(mainStop), .pinEn(pinEn), .lowOscOff(lowOscOff),
    .highOscEn(highOscEn), .highOscSel(highOscSel), .divField(divField),
    .div8Ovr(div8Ovr), .cpuClkEn(cpuClkEn), .activeSrc(activeSrc),
    .activeDiv(activeDiv), .cfgErr(cfgErr)
  );

  function automatic int reqDivOf(bit ovr, logic [1:0] f);
    if (ovr) return 8;            // R2
    case (f)                      // R1
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic int reqSrcOf(output bit ok);
    ok = 1;                                        // R3 decode
    if (!srcSel) begin ok = !mainStop && pinEn; return 0; end
    if (highOscSel && highOscEn) return 2;
    if (!highOscSel && !lowOscOff) return 1;
    ok = 0;
    return 0;
  endfunction

  function automatic bit tickOf(int s);
    return (s == 0) ? mainTick : (s == 1) ? lowTick : highTick;
  endfunction

  function automatic bit stableOf(int s);
    return (s == 0) ? mainStable : (s == 1) ? lowStable : highStable;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mSrc = 1; mDiv = 8; mCnt = 0; mErr = 0;
    end else begin
      bit ok;
      int rs;
      bit tk;
      rs = reqSrcOf(ok);
      tk = tickOf(mSrc);
      mErr = !srcSel && (mainStop || !pinEn);
      if (ok && rs != mSrc && stableOf(rs)) begin
        mSrc = rs; mCnt = 0; mDiv = reqDivOf(div8Ovr, divField);
      end else if (tk) begin
        if (mCnt == mDiv - 1) begin
          mCnt = 0; mDiv = reqDivOf(div8Ovr, divField);
        end else mCnt = mCnt + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn && !rst) begin
      check("R8 cpuClkEn", cpuClkEn, tickOf(mSrc) && (mCnt == mDiv - 1));
      check("R4 activeSrc", activeSrc, mSrc);
      check("R6 activeDiv", activeDiv, mDiv);
      check("R5 cfgErr", cfgErr, mErr);
    end
  end

  always @(posedge clk) begin
    #1;
    mainTick <= ($urandom_range(0, 1) == 1);
    lowTick  <= ($urandom_range(0, 4) == 0);
    highTick <= ($urandom_range(0, 3) != 0);
    if (randStable) begin
      mainStable <= ($urandom_range(0, 9) != 0);
      lowStable  <= ($urandom_range(0, 9) != 0);
      highStable <= ($urandom_range(0, 9) != 0);
    end
  end

  task automatic stepCycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset cpuClkEn", cpuClkEn, 0);
    check("R7 reset activeSrc", activeSrc, 1);
    check("R7 reset activeDiv", activeDiv, 8);
    check("R7 reset cfgErr", cfgErr, 0);
    @(posedge clk); #1;
    rst = 0;
    checkOn = 1;
    @(negedge clk);
    check("R7 post-reset activeSrc", activeSrc, 1);
    check("R7 post-reset activeDiv", activeDiv, 8);

    // R1: divide-by-2 request reaches activeDiv after a boundary
    div8Ovr = 0; divField = 2'b01;
    stepCycles(100);
    @(negedge clk);
    check("R1 divField 01", activeDiv, 2);
    // R2: override wins over field 11
    div8Ovr = 1; divField = 2'b11;
    stepCycles(100);
    @(negedge clk);
    check("R2 override", activeDiv, 8);

    // R4: high requested but not stable -> stays low
    highStable = 0; highOscEn = 1; highOscSel = 1; srcSel = 1;
    stepCycles(20);
    @(negedge clk);
    check("R4 pending hold", activeSrc, 1);
    @(posedge clk); #1;
    highStable = 1;
    @(negedge clk);
    check("R4 before edge", activeSrc, 1);
    @(negedge clk);
    check("R4 switch taken", activeSrc, 2);

    // R3: srcSel=1, highOscSel=0, lowOscOff=1 is ignored
    highOscSel = 0; lowOscOff = 1;
    stepCycles(10);
    @(negedge clk);
    check("R3 illegal on-chip ignored", activeSrc, 2);

    // R5: main requested while stopped
    srcSel = 0; mainStop = 1; mainStable = 1;
    stepCycles(1);
    @(negedge clk);
    check("R5 err raised", cfgErr, 1);
    check("R5 src kept", activeSrc, 2);
    mainStop = 0; pinEn = 0;
    stepCycles(3);
    @(negedge clk);
    check("R5 pin disabled", activeSrc, 2);
    pinEn = 1;
    stepCycles(1);
    @(negedge clk);
    check("R5 err cleared", cfgErr, 0);
    check("R3 main taken", activeSrc, 0);

    // R8/R9/R6: random configurations
    randStable = 1;
    for (int seg = 0; seg < 120; seg++) begin
      srcSel     = $urandom_range(0, 1);
      mainStop   = ($urandom_range(0, 4) == 0);
      pinEn      = ($urandom_range(0, 4) != 0);
      lowOscOff  = ($urandom_range(0, 3) == 0);
      highOscEn  = $urandom_range(0, 1);
      highOscSel = $urandom_range(0, 1);
      divField   = 2'($urandom_range(0, 3));
      div8Ovr    = ($urandom_range(0, 3) == 0);
      stepCycles($urandom_range(20, 80));
    end

    // R8: divide-by-1 on low source pulses on every low tick
    randStable = 0;
    lowStable = 1; srcSel = 1; highOscSel = 0; lowOscOff = 0;
    div8Ovr = 0; divField = 2'b00;
    stepCycles(60);
    @(negedge clk);
    check("R9 low code", activeSrc, 1);
    check("R1 div1", activeDiv, 1);
    divField = 2'b11;
    stepCycles(120);
    @(negedge clk);
    check("R1 div16", activeDiv, 16);

    checkOn = 0;
    summary();
    $finish;
  end
endmodule